// File: doc/BRIEF.md
# Pipelined Burst SRAM Model

This block models a synchronous burst static RAM with registered inputs and a registered read path. Every rising clock edge samples an address, two address strobes of different priority, a burst-advance input, three chip enables and a set of write enables. From them it classifies the cycle as a deselect, a burst start, a burst step or a burst pause, and as a read or a write. Writes land in an internal word array under a per-byte mask; read data arrives on a separate output bus one edge after the edge that sampled the command. An output-valid flag marks the cycles in which a real memory would drive its pins.

A burst covers four words that share all address bits above bit 1. The two low bits follow either an exclusive-or order or a wrapping increment order, chosen by a static select input. An asynchronous output enable can blank the output without disturbing anything inside, and a sleep input freezes the whole block, array included, until it drops.

Top module: `burst_sram_model`

## Requirements
- R1: The chip counts as selected only when `en_a_n` is 0, `en_b` is 1 and `en_c_n` is 0. Either strobe low while not selected is a deselect: no access is made and the output is invalid after the following edge.
- R2: `host_strb_n` low while selected starts a burst at `addr` and is always a read, even when the write enables request a write; it wins over `ctrl_strb_n`.
- R3: With `host_strb_n` high, `ctrl_strb_n` low and the chip selected, a burst starts at `addr`; it writes when the write condition (R6) holds and reads otherwise.
- R4: With both strobes high during an active burst, `adv_n` low moves to the next word. The burst address keeps `addr[ADDR_W-1:2]` of the start address; its low two bits are start XOR step when `seq_linear` is 0 and (start + step) mod 4 when `seq_linear` is 1, the step counting 1, 2, 3 and then wrapping to 0.
- R5: With both strobes high during an active burst, `adv_n` high repeats the current word. In step and pause cycles the chip enables are ignored.
- R6: The write condition holds when `all_wr_n` is 0 (all bytes written) or when `bw_n` is 0 and at least one bit of `lane_n` is 0 (only those bytes written; `lane_n[i]` guards `din[8i+7:8i]`). Otherwise the cycle is a read.
- R7: The word read for a command sampled at edge k appears on `dout` with `dout_vld` high after edge k+1.
- R8: After a deselect the block stays idle, with no access and an invalid output, through cycles with both strobes high, until a new burst starts.
- R9: `oe_n` high forces `dout_vld` to 0 and `dout` to zero without changing internal state; the output is also invalid after a write.
- R10: While `sleep` is high every command is ignored, the array and all internal state are held, and `dout_vld` is 0; operation resumes when `sleep` falls.
- R11: A read issued in the cycle after a write to the same address returns the new data.
- R12: During and right after reset `dout_vld` is 0, `dout` is zero and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address sampled on a burst start |
| host_strb_n | input | 1 | High-priority address strobe, always starts a read |
| ctrl_strb_n | input | 1 | Low-priority address strobe, read or write |
| adv_n | input | 1 | Burst advance, active low |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| all_wr_n | input | 1 | Write all bytes, active low |
| bw_n | input | 1 | Byte-write master enable, active low |
| lane_n | input | BYTES | Per-byte write enables, active low |
| din | input | BYTES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Freeze request, active high |
| seq_linear | input | 1 | Burst order: 1 increment, 0 exclusive-or |
| dout | output | BYTES*LANE_W | Read data, zero when invalid |
| dout_vld | output | 1 | Read data valid |

## Verification
The strobe and enable combinations are crossed with every write-enable combination, so the bench separates host-strobe reads that ignore a write request from controller-strobe writes, and deselects from accepted starts. Bursts from several start offsets in both orders distinguish the exclusive-or and increment sequences, and pauses with deasserted chip enables show that step cycles ignore selection. Partial byte masks against a known background expose lane mapping faults, while write-then-read pairs, sleep windows with pending write commands and output-enable blanking cover the pipeline timing. A long random stream with a fixed seed and a reference model then mixes all of these, including sleep inside bursts and order changes.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

   typedef enum logic [2:0] {
      CMD_NONE  = 3'd0,
      CMD_DESEL = 3'd1,
      CMD_BEGIN = 3'd2,
      CMD_ADV   = 3'd3,
      CMD_HOLD  = 3'd4
   } cmd_e;

   // low two address bits of burst word number idx starting from start
   function automatic logic [1:0] burst_low(input logic [1:0] start,
                                            input logic [1:0] idx,
                                            input logic       lin);
      logic [1:0] r;
      if (lin) r = start + idx;
      else     r = start ^ idx;
      return r;
   endfunction

endpackage

// File: rtl/sbm_decode.sv
module sbm_decode
   import sbm_pkg::*;
#(
   parameter int BYTES = 4
) (
   input  logic             sleep,
   input  logic             host_strb_n,
   input  logic             ctrl_strb_n,
   input  logic             adv_n,
   input  logic             en_a_n,
   input  logic             en_b,
   input  logic             en_c_n,
   input  logic             all_wr_n,
   input  logic             bw_n,
   input  logic [BYTES-1:0] lane_n,
   input  logic             active,
   output cmd_e             cmd,
   output logic [BYTES-1:0] lane_we
);

   logic             sel;
   logic [BYTES-1:0] want;

   always_comb begin
      sel = !en_a_n && en_b && !en_c_n;
      if (!all_wr_n)  want = '1;
      else if (!bw_n) want = ~lane_n;
      else            want = '0;

      cmd     = CMD_NONE;
      lane_we = '0;
      if (!sleep) begin
         if (!host_strb_n) begin
            cmd = sel ? CMD_BEGIN : CMD_DESEL;
         end else if (!ctrl_strb_n) begin
            if (sel) begin
               cmd     = CMD_BEGIN;
               lane_we = want;
            end else begin
               cmd = CMD_DESEL;
            end
         end else if (active) begin
            cmd     = adv_n ? CMD_HOLD : CMD_ADV;
            lane_we = want;
         end
      end
   end

endmodule

// File: rtl/sbm_burst.sv
module sbm_burst
   import sbm_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cmd_e              cmd,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic              lin,
   output logic              active,
   output logic [ADDR_W-1:0] acc_addr
);

   localparam int HI_W = ADDR_W - 2;

   logic [ADDR_W-1:0] base_q;
   logic [1:0]        step_q;
   logic              act_q;

   always_comb begin
      case (cmd)
         CMD_BEGIN: acc_addr = ext_addr;
         CMD_ADV:   acc_addr = {base_q[ADDR_W-1:2],
                                burst_low(base_q[1:0], step_q + 2'd1, lin)};
         default:   acc_addr = {base_q[ADDR_W-1:2],
                                burst_low(base_q[1:0], step_q, lin)};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         step_q <= '0;
         act_q  <= 1'b0;
      end else begin
         case (cmd)
            CMD_BEGIN: begin
               base_q <= ext_addr;
               step_q <= '0;
               act_q  <= 1'b1;
            end
            CMD_ADV:   step_q <= step_q + 2'd1;
            CMD_DESEL: act_q  <= 1'b0;
            default: ;
         endcase
      end
   end

   assign active = act_q;

   if (HI_W < 1) begin : g_bad_addr
      $error("sbm_burst: ADDR_W must be at least 3");
   end

   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_ADV |=> step_q == $past(step_q) + 2'd1);

   p_pause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_HOLD |=> $stable(step_q) && $stable(base_q));

   p_desel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_DESEL |=> !act_q);

   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_q && cmd != CMD_BEGIN) |=> !act_q);

endmodule

// File: rtl/sbm_store.sv
module sbm_store #(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    hold,
   input  logic                    req_rd,
   input  logic [BYTES-1:0]        req_we,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [BYTES*LANE_W-1:0] req_data,
   output logic                    out_vld,
   output logic [BYTES*LANE_W-1:0] out_data
);

   localparam int DATA_W = BYTES * LANE_W;
   localparam int DEPTH  = 1 << ADDR_W;

   logic              s1_rd;
   logic [BYTES-1:0]  s1_we;
   logic [ADDR_W-1:0] s1_addr;
   logic [DATA_W-1:0] s1_data;
   logic              vld_q;
   logic [DATA_W-1:0] rd_all;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_rd   <= 1'b0;
         s1_we   <= '0;
         s1_addr <= '0;
         s1_data <= '0;
         vld_q   <= 1'b0;
      end else if (!hold) begin
         s1_rd   <= req_rd;
         s1_we   <= req_we;
         s1_addr <= req_addr;
         s1_data <= req_data;
         vld_q   <= s1_rd;
      end
   end

   for (genvar i = 0; i < BYTES; i++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] rd_q;

      always_ff @(posedge clk) begin
         if (!hold && s1_we[i]) mem[s1_addr] <= s1_data[i*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                rd_q <= '0;
         else if (!hold && s1_rd)   rd_q <= mem[s1_addr];
      end

      assign rd_all[i*LANE_W +: LANE_W] = rd_q;
   end

   assign out_vld  = vld_q;
   assign out_data = rd_all;

   p_wr_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && (|s1_we)) |=> !vld_q);

   p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(vld_q) && $stable(s1_rd) && $stable(s1_we) && $stable(s1_addr));

endmodule

// File: rtl/burst_sram_model.sv
module burst_sram_model
   import sbm_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int BYTES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    host_strb_n,
   input  logic                    ctrl_strb_n,
   input  logic                    adv_n,
   input  logic                    en_a_n,
   input  logic                    en_b,
   input  logic                    en_c_n,
   input  logic                    all_wr_n,
   input  logic                    bw_n,
   input  logic [BYTES-1:0]        lane_n,
   input  logic [BYTES*LANE_W-1:0] din,
   input  logic                    oe_n,
   input  logic                    sleep,
   input  logic                    seq_linear,
   output logic [BYTES*LANE_W-1:0] dout,
   output logic                    dout_vld
);

   localparam int DATA_W = BYTES * LANE_W;

   cmd_e              cmd;
   logic [BYTES-1:0]  lane_we;
   logic              active;
   logic [ADDR_W-1:0] acc_addr;
   logic              req_rd;
   logic              out_vld;
   logic [DATA_W-1:0] out_data;

   if (BYTES < 1 || LANE_W < 1) begin : g_bad_width
      $error("burst_sram_model: BYTES and LANE_W must be positive");
   end

   sbm_decode #(.BYTES(BYTES)) u_dec (
      .sleep       (sleep),
      .host_strb_n (host_strb_n),
      .ctrl_strb_n (ctrl_strb_n),
      .adv_n       (adv_n),
      .en_a_n      (en_a_n),
      .en_b        (en_b),
      .en_c_n      (en_c_n),
      .all_wr_n    (all_wr_n),
      .bw_n        (bw_n),
      .lane_n      (lane_n),
      .active      (active),
      .cmd         (cmd),
      .lane_we     (lane_we)
   );

   sbm_burst #(.ADDR_W(ADDR_W)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .ext_addr (addr),
      .lin      (seq_linear),
      .active   (active),
      .acc_addr (acc_addr)
   );

   assign req_rd = (cmd inside {CMD_BEGIN, CMD_ADV, CMD_HOLD}) && (lane_we == '0);

   sbm_store #(.ADDR_W(ADDR_W), .BYTES(BYTES), .LANE_W(LANE_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (sleep),
      .req_rd   (req_rd),
      .req_we   (lane_we),
      .req_addr (acc_addr),
      .req_data (din),
      .out_vld  (out_vld),
      .out_data (out_data)
   );

   assign dout_vld = out_vld && !oe_n && !sleep;
   assign dout     = dout_vld ? out_data : '0;

   logic chip_sel;
   assign chip_sel = !en_a_n && en_b && !en_c_n;

   p_host_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !host_strb_n && chip_sel) |=> u_store.s1_rd && (u_store.s1_we == '0));

   p_nosel_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && (!host_strb_n || !ctrl_strb_n) && !chip_sel)
         |=> !u_store.s1_rd && (u_store.s1_we == '0));

   p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !dout_vld);

endmodule

// File: tb/burst_sram_model_bench.sv
`timescale 1ns/1ps
module burst_sram_model_bench;

   localparam int AW = 6;
   localparam int NB = 4;
   localparam int LW = 8;
   localparam int DW = NB * LW;
   localparam int NW = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr;
   logic          host_strb_n, ctrl_strb_n, adv_n;
   logic          en_a_n, en_b, en_c_n;
   logic          all_wr_n, bw_n;
   logic [NB-1:0] lane_n;
   logic [DW-1:0] din;
   logic          oe_n, sleep, seq_linear;
   logic [DW-1:0] dout;
   logic          dout_vld;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   burst_sram_model #(.ADDR_W(AW), .BYTES(NB), .LANE_W(LW)) u_burst_sram_model (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .host_strb_n(host_strb_n), .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n),
      .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
      .all_wr_n(all_wr_n), .bw_n(bw_n), .lane_n(lane_n), .din(din),
      .oe_n(oe_n), .sleep(sleep), .seq_linear(seq_linear),
      .dout(dout), .dout_vld(dout_vld)
   );

   // reference model state
   logic [DW-1:0] mm [NW];
   logic          m_act;
   logic [AW-1:0] m_base;
   logic [1:0]    m_step;
   logic          m_s1rd;
   logic [NB-1:0] m_s1we;
   logic [AW-1:0] m_s1addr;
   logic [DW-1:0] m_s1data;
   logic          m_ovld;
   logic [DW-1:0] m_odata;

   function automatic logic [AW-1:0] word_at(logic [AW-1:0] b, logic [1:0] k, logic lin);
      logic [1:0] lo;
      lo = lin ? 2'((b[1:0] + k) & 2'd3) : (b[1:0] ^ k);
      return {b[AW-1:2], lo};
   endfunction

   task automatic model_reset();
      m_act = 0; m_base = '0; m_step = '0;
      m_s1rd = 0; m_s1we = '0; m_s1addr = '0; m_s1data = '0;
      m_ovld = 0; m_odata = '0;
   endtask

   task automatic model_step();
      logic          sel, access, wr_ok;
      logic [NB-1:0] wl;
      logic [AW-1:0] where;
      if (sleep) return;
      if (m_s1rd) m_odata = mm[m_s1addr];
      for (int k = 0; k < NB; k++)
         if (m_s1we[k]) mm[m_s1addr][k*LW +: LW] = m_s1data[k*LW +: LW];
      m_ovld = m_s1rd;
      sel = !en_a_n && en_b && !en_c_n;
      wl  = !all_wr_n ? {NB{1'b1}} : (!bw_n ? ~lane_n : '0);
      access = 0; wr_ok = 0; where = '0;
      if (!host_strb_n || !ctrl_strb_n) begin
         if (sel) begin
            access = 1; wr_ok = host_strb_n;
            m_act = 1; m_base = addr; m_step = 0; where = addr;
         end else begin
            m_act = 0;
         end
      end else if (m_act) begin
         access = 1; wr_ok = 1;
         if (!adv_n) m_step = m_step + 2'd1;
         where = word_at(m_base, m_step, seq_linear);
      end
      m_s1we   = (access && wr_ok) ? wl : '0;
      m_s1rd   = access && (m_s1we == '0);
      m_s1addr = where;
      m_s1data = din;
   endtask

   task automatic check(string tag, logic gv, logic ev, logic [DW-1:0] gd, logic [DW-1:0] ed);
      n_cmp++;
      if (gv !== ev || gd !== ed) begin
         n_bad++;
         $display("FAIL %s: vld=%0b data=%h expected vld=%0b data=%h", tag, gv, gd, ev, ed);
      end
   endtask

   task automatic idle();
      host_strb_n = 1; ctrl_strb_n = 1; adv_n = 1;
      en_a_n = 0; en_b = 1; en_c_n = 0;
      all_wr_n = 1; bw_n = 1; lane_n = '1;
      oe_n = 0; sleep = 0; din = '0;
   endtask

   // one clock: inputs already set at a falling edge
   task automatic cyc(string tag);
      logic ev;
      model_step();
      @(posedge clk);
      @(negedge clk);
      ev = m_ovld && !oe_n && !sleep;
      check(tag, dout_vld, ev, dout, ev ? m_odata : '0);
      idle();
   endtask

   task automatic start_wr(logic [AW-1:0] a, logic [DW-1:0] d, string tag);
      ctrl_strb_n = 0; all_wr_n = 0; addr = a; din = d; cyc(tag);
   endtask

   task automatic start_rd(logic [AW-1:0] a, string tag);
      host_strb_n = 0; addr = a; cyc(tag);
   endtask

   task automatic step(logic wr, logic [DW-1:0] d, string tag);
      adv_n = 0; all_wr_n = !wr; din = d; cyc(tag);
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      idle(); addr = '0; seq_linear = 0;
      model_reset();
      repeat (3) @(negedge clk);
      check("R12", dout_vld, 1'b0, dout, '0);
      rst_n = 1;
      cyc("R12");

      // fill the array
      for (int i = 0; i < NW; i++) start_wr(AW'(i), (DW'(i) * 32'h0101_0101) ^ 32'hA500_0000, "R3");
      cyc("R3");

      // write burst, then host read burst with write request present
      start_wr(6'd4, 32'h1111_1111, "R3");
      step(1, 32'h2222_2222, "R4");
      step(1, 32'h3333_3333, "R4");
      step(1, 32'h4444_4444, "R4");
      host_strb_n = 0; all_wr_n = 0; addr = 6'd4; din = 32'hBAD0_BAD0; cyc("R2");
      step(0, '0, "R7");
      step(0, '0, "R4");
      step(0, '0, "R4");
      en_a_n = 1; cyc("R5");
      en_b = 0; adv_n = 0; cyc("R5");
      cyc("R5");

      // exclusive-or order from offset 1, increment order from offset 2
      start_rd(6'd5, "R4");
      step(0, '0, "R4"); step(0, '0, "R4"); step(0, '0, "R4"); step(0, '0, "R4");
      seq_linear = 1;
      start_rd(6'd6, "R4");
      step(0, '0, "R4"); step(0, '0, "R4"); step(0, '0, "R4"); step(0, '0, "R4");
      seq_linear = 0;

      // byte masks
      ctrl_strb_n = 0; bw_n = 0; lane_n = 4'b1010; addr = 6'd10; din = 32'hFFFF_FFFF; cyc("R6");
      ctrl_strb_n = 0; bw_n = 0; lane_n = 4'b1111; addr = 6'd10; din = 32'h0; cyc("R6");
      ctrl_strb_n = 0; bw_n = 1; lane_n = 4'b0000; addr = 6'd10; din = 32'h0; cyc("R6");
      cyc("R6");
      ctrl_strb_n = 0; bw_n = 0; lane_n = 4'b0111; addr = 6'd11; din = 32'h7777_7777; cyc("R6");
      start_rd(6'd11, "R6"); cyc("R6");

      // read right after write
      start_wr(6'd12, 32'hCAFE_F00D, "R11");
      start_rd(6'd12, "R11");
      cyc("R11");

      // deselect and idle until a new start
      start_rd(6'd20, "R8");
      host_strb_n = 0; en_b = 0; cyc("R8");
      cyc("R8"); cyc("R8"); adv_n = 0; cyc("R8");
      start_rd(6'd21, "R1");
      ctrl_strb_n = 0; en_c_n = 1; all_wr_n = 0; addr = 6'd21; din = 32'h1; cyc("R1");
      ctrl_strb_n = 0; en_a_n = 1; addr = 6'd22; cyc("R1");
      cyc("R1");
      start_rd(6'd21, "R1"); cyc("R1");

      // output enable blanking and write cycles
      start_rd(6'd30, "R9");
      oe_n = 1; adv_n = 0; cyc("R9");
      step(0, '0, "R9");
      start_wr(6'd31, 32'h3131_3131, "R9");
      cyc("R9");

      // sleep with pending write commands
      start_rd(6'd40, "R10");
      sleep = 1; ctrl_strb_n = 0; all_wr_n = 0; addr = 6'd40; din = 32'hDEAD_DEAD; cyc("R10");
      sleep = 1; host_strb_n = 0; addr = 6'd41; cyc("R10");
      cyc("R10");
      start_rd(6'd40, "R10"); cyc("R10");

      // random traffic
      for (int n = 0; n < 4000; n++) begin
         int pick;
         pick = $urandom % 10;
         host_strb_n = (pick != 0);
         ctrl_strb_n = !(pick == 1 || pick == 2);
         adv_n    = $urandom % 2;
         en_a_n   = ($urandom % 8) == 0;
         en_b     = ($urandom % 8) != 0;
         en_c_n   = ($urandom % 8) == 0;
         all_wr_n = ($urandom % 4) != 0;
         bw_n     = $urandom % 2;
         lane_n   = NB'($urandom);
         din      = DW'($urandom);
         addr     = AW'($urandom);
         oe_n     = ($urandom % 8) == 0;
         sleep    = ($urandom % 16) == 0;
         if (n % 250 == 0) seq_linear = $urandom % 2;
         cyc("R7");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule